// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block is one receive channel for an ARINC 429 link. It watches two return-to-zero input lines, one that pulses for a logic one and one that pulses for a logic zero, and builds 32-bit words from the pulses. A completed word is checked for length, for illegal symbols and for parity. It is then kept only if its label, the first eight bits on the line, is enabled in an internal 256-entry label memory.

The last accepted word sits in a hold buffer that a 16-bit host reads as two halves. Two single-cycle events are raised: one when a word is accepted and one when a complete word fails its parity check. A small register port lets the host set the parity mode, the sampling rate and the loopback select. The same port gives write and read-back access to the label memory for self-test. With loopback selected, the channel listens to a pair of lines from a local transmitter instead of the external lines.

Top module: `a429_rx_chan`

## Requirements
- R1: After reset the control, divider and label pointer registers read 0, every label is disabled, both buffer halves read 0, and neither event is raised.
- R2: Bits are taken in arrival order. The first bit lands in word bit 0. The host reads word bits 15:0 at address 4 and bits 31:16 at address 5.
- R3: A word is accepted only when the label memory entry selected by word bits 7:0 is set. A word with a disabled label changes nothing and raises no event.
- R4: Control bits 1:0 select the parity check: 01 requires an odd number of ones in all 32 bits, 10 requires an even number, and 00 or 11 disables the check.
- R5: A complete 32-bit word that fails the selected parity check raises the bad-parity event for one cycle, whatever its label. It leaves the buffer unchanged and raises no valid event.
- R6: A word with any bit count other than 32 is discarded with no event.
- R7: A sample with both lines high is illegal. It discards the word in progress with no event.
- R8: A word ends when both lines have been low for 16 sample ticks, which is two bit times of 8 ticks. Words separated by a shorter idle run merge into one over-long word.
- R9: Address 1 holds the divider N. The lines are sampled once every N+1 clock cycles.
- R10: Control bit 2 selects the loopback pair in place of the external lines. While it is set, activity on the external lines is ignored.
- R11: Address 2 holds the label pointer. Bit 0 written at address 3 sets or clears the label entry at the pointer, and a read of address 3 returns that entry.
- R12: The valid event and the bad-parity event each last one clock cycle, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_one_i | input | 1 | External line that pulses for a one |
| line_zero_i | input | 1 | External line that pulses for a zero |
| lpbk_one_i | input | 1 | Loopback line for ones, from a local transmitter |
| lpbk_zero_i | input | 1 | Loopback line for zeros, from a local transmitter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational on the address |
| msg_ok_o | output | 1 | Pulse: a word was accepted into the buffer |
| par_err_o | output | 1 | Pulse: a complete word failed parity |

## Verification
The channel is driven with complete words under each parity mode and with enabled and disabled labels, which separates label filtering from parity rejection. Words of 31 and 33 bits, and a word holding an illegal both-high symbol, show that only well-formed words reach the checks. Pairs of words with long and with short idle runs between them, sent at two divider settings, show whether the gap is measured in sample ticks rather than clock cycles. A loopback word sent while the external lines carry a different word shows which path is in use.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_OFF  = 2'b11
  } par_mode_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LPTR = 3'd2;
  localparam logic [ADDR_W-1:0] A_LBIT = 3'd3;
  localparam logic [ADDR_W-1:0] A_WLO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_WHI  = 3'd5;
endpackage

// File: rtl/a429_rx_tick.sv
module a429_rx_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/a429_rx_deser.sv
module a429_rx_deser #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned GAP_TICKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              one_i,
  input  logic              zero_i,
  output logic              done_o,
  output logic              len_ok_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam int unsigned GAP_W = $clog2(GAP_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]        sy_one_q, sy_zero_q;
  logic              prv_one_q, prv_zero_q;
  logic              s_one, s_zero, edge_seen;
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gap_q;
  logic              busy_q, bad_q;

  assign s_one     = sy_one_q[1];
  assign s_zero    = sy_zero_q[1];
  assign edge_seen = (s_one && !prv_one_q) || (s_zero && !prv_zero_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sy_one_q  <= '0;
      sy_zero_q <= '0;
    end else begin
      sy_one_q  <= {sy_one_q[0], one_i};
      sy_zero_q <= {sy_zero_q[0], zero_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_one_q  <= 1'b0;
      prv_zero_q <= 1'b0;
      shreg_q    <= '0;
      cnt_q      <= '0;
      gap_q      <= '0;
      busy_q     <= 1'b0;
      bad_q      <= 1'b0;
      done_o     <= 1'b0;
      len_ok_o   <= 1'b0;
      word_o     <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        prv_one_q  <= s_one;
        prv_zero_q <= s_zero;
        if (s_one && s_zero) begin
          bad_q  <= 1'b1;
          busy_q <= 1'b1;
          gap_q  <= '0;
        end else if (edge_seen) begin
          shreg_q <= {s_one, shreg_q[WORD_W-1:1]};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          busy_q <= 1'b1;
          gap_q  <= '0;
        end else if (s_one || s_zero) begin
          gap_q <= '0;
        end else if (busy_q) begin
          if (gap_q == GAP_W'(GAP_TICKS - 1)) begin
            done_o   <= 1'b1;
            len_ok_o <= (cnt_q == CNT_W'(WORD_W)) && !bad_q;
            word_o   <= shreg_q;
            busy_q   <= 1'b0;
            bad_q    <= 1'b0;
            cnt_q    <= '0;
            gap_q    <= '0;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/a429_rx_lblmem.sv
module a429_rx_lblmem #(
  parameter int unsigned LBL_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [LBL_W-1:0]      waddr_i,
  input  logic                  wbit_i,
  output logic [(1<<LBL_W)-1:0] mem_o
);
  localparam int unsigned N_LBL = 1 << LBL_W;

  for (genvar g = 0; g < N_LBL; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_o[g] <= 1'b0;
      else if (we_i && (waddr_i == LBL_W'(g)))       mem_o[g] <= wbit_i;
    end
  end
endmodule

// File: rtl/a429_rx_chan.sv
module a429_rx_chan
  import a429_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LBL_W  = 8,
  parameter int unsigned SPB    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_one_i,
  input  logic              line_zero_i,
  input  logic              lpbk_one_i,
  input  logic              lpbk_zero_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              msg_ok_o,
  output logic              par_err_o
);
  localparam int unsigned WORD_W = 2 * DATA_W;
  localparam int unsigned N_LBL  = 1 << LBL_W;
  localparam int unsigned GAP_T  = 2 * SPB;

  logic [2:0]        ctrl_q;
  logic [DATA_W-1:0] div_q;
  logic [LBL_W-1:0]  lptr_q;
  logic [WORD_W-1:0] buf_q;
  logic [N_LBL-1:0]  lbl_vec;
  logic              tick, in_one, in_zero;
  logic              done, len_ok, par_ok, lbl_hit, lbl_we;
  logic [WORD_W-1:0] word;
  par_mode_e         mode;

  assign mode    = par_mode_e'(ctrl_q[1:0]);
  assign in_one  = ctrl_q[2] ? lpbk_one_i  : line_one_i;
  assign in_zero = ctrl_q[2] ? lpbk_zero_i : line_zero_i;
  assign lbl_we  = reg_wr_i && (reg_addr_i == A_LBIT);
  assign lbl_hit = lbl_vec[word[LBL_W-1:0]];

  a429_rx_tick #(.DIV_W(DATA_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_q), .tick_o(tick)
  );

  a429_rx_deser #(.WORD_W(WORD_W), .GAP_TICKS(GAP_T)) u_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .one_i(in_one), .zero_i(in_zero),
    .done_o(done), .len_ok_o(len_ok), .word_o(word)
  );

  a429_rx_lblmem #(.LBL_W(LBL_W)) u_lbl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(lbl_we),
    .waddr_i(lptr_q), .wbit_i(reg_wdata_i[0]), .mem_o(lbl_vec)
  );

  always_comb begin
    unique case (mode)
      PAR_ODD:  par_ok = ^word;
      PAR_EVEN: par_ok = ~^word;
      default:  par_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      div_q  <= '0;
      lptr_q <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_CTRL:  ctrl_q <= reg_wdata_i[2:0];
        A_DIV:   div_q  <= reg_wdata_i;
        A_LPTR:  lptr_q <= reg_wdata_i[LBL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q     <= '0;
      msg_ok_o  <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      msg_ok_o  <= 1'b0;
      par_err_o <= 1'b0;
      if (done && len_ok) begin
        if (!par_ok) begin
          par_err_o <= 1'b1;
        end else if (lbl_hit) begin
          msg_ok_o <= 1'b1;
          buf_q    <= word;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = DATA_W'(ctrl_q);
      A_DIV:   reg_rdata_o = div_q;
      A_LPTR:  reg_rdata_o = DATA_W'(lptr_q);
      A_LBIT:  reg_rdata_o = DATA_W'(lbl_vec[lptr_q]);
      A_WLO:   reg_rdata_o = buf_q[DATA_W-1:0];
      A_WHI:   reg_rdata_o = buf_q[WORD_W-1:DATA_W];
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LBL_W  = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  msg_ok_i,
  input logic                  par_err_i,
  input logic [WORD_W-1:0]     buf_i,
  input logic [1:0]            mode_i,
  input logic [(1<<LBL_W)-1:0] lbl_i
);
  logic [(1<<LBL_W)-1:0] lbl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lbl_d <= '0;
    else         lbl_d <= lbl_i;
  end

  p_evt_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({msg_ok_i, par_err_i}));

  p_msg_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ok_i |=> !msg_ok_i);

  p_perr_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_i |=> !par_err_i);

  p_buf_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_ok_i |-> $stable(buf_i));

  p_par_odd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_ok_i && $past(mode_i) == 2'b01) |-> (^buf_i));

  p_par_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_ok_i && $past(mode_i) == 2'b10) |-> !(^buf_i));

  p_perr_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_i |-> ($past(mode_i) == 2'b01 || $past(mode_i) == 2'b10));

  p_lbl_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ok_i |-> lbl_d[buf_i[LBL_W-1:0]]);
endmodule

bind a429_rx_chan a429_rx_chk #(.WORD_W(WORD_W), .LBL_W(LBL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_ok_i(msg_ok_o), .par_err_i(par_err_o),
  .buf_i(buf_q), .mode_i(ctrl_q[1:0]), .lbl_i(lbl_vec)
);

// File: tb/sim_a429_rx_chan.sv
module sim_a429_rx_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l1 = 1'b0, l0 = 1'b0, p1 = 1'b0, p0 = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rdata;
  logic msg_ok, par_err;

  int total = 0, bad = 0, mon_chk = 0, mon_bad = 0;
  int act_msg = 0, act_perr = 0, exp_msg = 0, exp_perr = 0;
  logic [255:0] m_lbl = '0;
  logic [31:0] m_buf = '0;
  logic [1:0] m_mode = 2'b00;

  always #2 clk = ~clk;

  a429_rx_chan u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .line_one_i(l1), .line_zero_i(l0), .lpbk_one_i(p1), .lpbk_zero_i(p0),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .msg_ok_o(msg_ok), .par_err_o(par_err)
  );

  // per-clock monitor: event counting and exclusivity (R12)
  always @(negedge clk) begin
    if (rst_n) begin
      if (msg_ok) act_msg++;
      if (par_err) act_perr++;
      mon_chk++;
      if (msg_ok && par_err) begin
        mon_bad++;
        $display("FAIL R12 both events high act=11 exp=0x");
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = rdata;
  endtask

  task automatic set_lbl(input logic [7:0] lab, input logic en);
    wr(3'd2, {8'h00, lab});
    wr(3'd3, {15'h0, en});
    m_lbl[lab] = en;
  endtask

  task automatic set_ctrl(input logic lp, input logic [1:0] mode);
    wr(3'd0, {13'h0, lp, mode});
    m_mode = mode;
  endtask

  task automatic set_lines(input logic lp, input logic a, input logic b);
    if (lp) begin p1 = a; p0 = b; end
    else    begin l1 = a; l0 = b; end
  endtask

  // bad_idx >= 0 drives both lines high for that bit (illegal symbol)
  task automatic drive(input logic [63:0] bits, input int n, input int bad_idx,
                       input int unit, input bit lp, input int gap_ticks);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == bad_idx) set_lines(lp, 1'b1, 1'b1);
      else              set_lines(lp, bits[i], ~bits[i]);
      repeat (4 * unit - 1) @(negedge clk);
      set_lines(lp, 1'b0, 1'b0);
      repeat (4 * unit) @(negedge clk);
    end
    repeat (gap_ticks * unit) @(negedge clk);
  endtask

  // reference model of one complete, well-framed word
  task automatic model_word(input logic [31:0] w);
    logic pok;
    case (m_mode)
      2'b01:   pok = ($countones(w) % 2) == 1;
      2'b10:   pok = ($countones(w) % 2) == 0;
      default: pok = 1'b1;
    endcase
    if (!pok) exp_perr++;
    else if (m_lbl[w[7:0]]) begin exp_msg++; m_buf = w; end
  endtask

  task automatic check_state(input string req);
    logic [15:0] v;
    chk({req, " valid events"}, act_msg, exp_msg);
    chk({req, " parity events"}, act_perr, exp_perr);
    rd(3'd4, v); chk({req, " buffer low"}, {16'h0, v}, {16'h0, m_buf[15:0]});
    rd(3'd5, v); chk({req, " buffer high"}, {16'h0, v}, {16'h0, m_buf[31:16]});
  endtask

  function automatic logic [31:0] with_par(input logic [30:0] d, input bit odd);
    logic p;
    p = ^d;
    return {odd ? ~p : p, d};
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total + mon_chk, bad + mon_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", {16'h0, v}, 0);
    rd(3'd1, v); chk("R1 div", {16'h0, v}, 0);
    rd(3'd2, v); chk("R1 pointer", {16'h0, v}, 0);
    rd(3'd3, v); chk("R1 label 0 disabled", {16'h0, v}, 0);
    check_state("R1");

    // R11 label memory write and read-back
    set_lbl(8'h5A, 1'b1);
    rd(3'd3, v); chk("R11 readback set", {16'h0, v}, 1);
    wr(3'd2, 16'h005B);
    rd(3'd3, v); chk("R11 neighbour clear", {16'h0, v}, 0);
    set_lbl(8'h5A, 1'b0);
    rd(3'd3, v); chk("R11 readback cleared", {16'h0, v}, 0);
    set_lbl(8'h5A, 1'b1);
    set_lbl(8'h31, 1'b1);

    // R2 basic assembly, no parity
    set_ctrl(1'b0, 2'b00);
    w = 32'hA5C3_105A;
    drive({32'h0, w}, 32, -1, 1, 1'b0, 24); model_word(w);
    check_state("R2");

    // R3 disabled label
    w = 32'h1234_5677;
    drive({32'h0, w}, 32, -1, 1, 1'b0, 24); model_word(w);
    check_state("R3");

    // R4 odd and even parity accepted
    set_ctrl(1'b0, 2'b01);
    w = with_par(31'h0ABC_DE31, 1'b1);
    drive({32'h0, w}, 32, -1, 1, 1'b0, 24); model_word(w);
    check_state("R4 odd");
    set_ctrl(1'b0, 2'b10);
    w = with_par(31'h3210_FE5A, 1'b0);
    drive({32'h0, w}, 32, -1, 1, 1'b0, 24); model_word(w);
    check_state("R4 even");

    // R5 parity failure, including a disabled label
    w = with_par(31'h0F0F_0031, 1'b1);
    drive({32'h0, w}, 32, -1, 1, 1'b0, 24); model_word(w);
    check_state("R5 enabled label");
    w = with_par(31'h0F0F_00EE, 1'b1);
    drive({32'h0, w}, 32, -1, 1, 1'b0, 24); model_word(w);
    check_state("R5 disabled label");

    // R6 wrong lengths
    set_ctrl(1'b0, 2'b00);
    drive({32'h0, 32'h7777_005A}, 31, -1, 1, 1'b0, 24);
    check_state("R6 short");
    drive({32'h1, 32'h7777_005A}, 33, -1, 1, 1'b0, 24);
    check_state("R6 long");

    // R7 illegal symbol
    drive({32'h0, 32'h6666_005A}, 32, 10, 1, 1'b0, 24);
    check_state("R7");

    // R8 long gap keeps words apart, short gap merges them
    w = 32'h1111_0031;
    drive({32'h0, w}, 32, -1, 1, 1'b0, 20); model_word(w);
    w = 32'h2222_005A;
    drive({32'h0, w}, 32, -1, 1, 1'b0, 24); model_word(w);
    check_state("R8 separate");
    drive({32'h0, 32'h3333_0031}, 32, -1, 1, 1'b0, 6);
    drive({32'h0, 32'h4444_005A}, 32, -1, 1, 1'b0, 24);
    check_state("R8 merged");

    // R9 divider: tick every 4 clocks, gap counted in ticks
    wr(3'd1, 16'd3);
    rd(3'd1, v); chk("R9 div readback", {16'h0, v}, 3);
    w = 32'h9999_0031;
    drive({32'h0, w}, 32, -1, 4, 1'b0, 24); model_word(w);
    check_state("R9 slow word");
    drive({32'h0, 32'h5555_005A}, 32, -1, 4, 1'b0, 10);
    drive({32'h0, 32'h6565_0031}, 32, -1, 4, 1'b0, 24);
    check_state("R9 gap in ticks");
    wr(3'd1, 16'd0);

    // R10 loopback path, external lines ignored
    set_ctrl(1'b1, 2'b00);
    w = 32'hBEEF_005A;
    drive({32'h0, w}, 32, -1, 1, 1'b1, 24); model_word(w);
    check_state("R10 loopback word");
    drive({32'h0, 32'hDEAD_0031}, 32, -1, 1, 1'b0, 24);
    check_state("R10 external ignored");

    finish_run();
  end
endmodule